// File: doc/BRIEF.md
# Sleep-Clamped General-Purpose I/O Port

This block is an 8-bit general-purpose I/O port that a processor reaches over a simple register bus. A direction register decides, for each pin, whether the pin drives or listens. A data register gives the level driven on output pins. On input pins, the same data bit turns on a pull-up. A third register reads the pin levels back after they have passed through a two-flop synchronizer. Because of that synchronizer, software has to allow an idle cycle between setting up a pin and reading it. A write to the read-back offset toggles data bits instead of loading them.

While the chip is in one of its deep sleep modes, the block forces the digital input of each pin to 0 ahead of the synchronizer. This stops floating or mid-rail inputs from toggling logic. The clamp does not act on a pin whose interrupt enable bit is set, so that pin keeps passing its real level while the chip sleeps.

Each pin also has a sticky change flag. It is set by any difference between successive synchronized samples of that pin. One result follows from this: a pin that is high when the chip leaves a deep sleep mode, and whose enable bit is clear, sets its flag, because its input goes from the clamped 0 back to 1. The flags are cleared by writing 1 to them. An interrupt output combines the flags with the enable bits.

Top module: `gpio_sleep_port`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, and pad_oe, pad_pu, pad_out and irq are 0.
- R2: pad_oe equals the direction register. pad_out equals the data bit where the direction bit is 1, and is 0 where it is 0.
- R3: pad_pu is 1 exactly where the direction bit is 0 and the data bit is 1.
- R4: The pin register returns the gated pad input after two rising clock edges. After only one edge it still shows the previous value.
- R5: The sleep_mode codes 2, 3, 6 and 7 are the deep modes, and in them the gated input is forced to 0. The codes 0, 1, 4 and 5 leave the input unclamped.
- R6: A pin whose interrupt enable bit is 1 bypasses the clamp and passes its real pad level in every mode.
- R7: A pin's flag is set one clock edge after its pin-register value changes, and it stays set. This includes a high pin with its enable bit clear that leaves a deep mode.
- R8: Writing to offset 4 clears each flag whose written bit is 1. Flags written with 0 keep their value. A new change in the same cycle as a clear wins, and the flag stays set.
- R9: Writing to offset 2 toggles each data bit whose written bit is 1. Data bits written with 0 are unchanged.
- R10: irq is 1 when any pin has both its flag and its enable bit set.
- R11: The read offsets are: 0 data, 1 direction, 2 pin (synchronized), 3 interrupt enable, 4 flags. Any other offset reads 0. Writes take effect on the clock edge at which wr_en is high. The read value follows addr without a register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| sleep_mode | input | 3 | Current sleep mode code |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Level driven on each pad |
| pad_oe | output | 8 | Output enable for each pad |
| pad_pu | output | 8 | Pull-up enable for each pad |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- a pin that is clamped and has its enable bit clear shows 0 at the first synchronizer stage;
- pull-up and output enable are never both on for the same pin;
- a flag holds until it is cleared;
- every change of the synchronized value sets its flag;
- a toggle write inverts exactly the selected data bits.

Only the bench's scenarios can show the end-to-end timing across the synchronizer, the mode-code decoding over all eight codes, and the wake-from-sleep flag sequence. The same holds for the interplay of partial clears with the interrupt output.

// File: rtl/gpio_port_pkg.sv
// Shared definitions for the sleep-clamped GPIO port.
// Assumes a 3-bit sleep mode code and 3-bit register offsets.
package gpio_port_pkg;

    typedef enum logic [2:0] {
        SM_RUN   = 3'd0,
        SM_IDLE  = 3'd1,
        SM_PDOWN = 3'd2,
        SM_PSAVE = 3'd3,
        SM_RSV4  = 3'd4,
        SM_RSV5  = 3'd5,
        SM_STBY  = 3'd6,
        SM_XSTBY = 3'd7
    } sleep_mode_e;

    localparam int OFF_DATA  = 0;
    localparam int OFF_DIR   = 1;
    localparam int OFF_PIN   = 2;
    localparam int OFF_IEN   = 3;
    localparam int OFF_FLAGS = 4;

    // True for the modes that clamp the inputs.
    function automatic logic is_deep(input logic [2:0] mode);
        sleep_mode_e m;
        m = sleep_mode_e'(mode);
        return (m == SM_PDOWN) || (m == SM_PSAVE) ||
               (m == SM_STBY)  || (m == SM_XSTBY);
    endfunction

endpackage

// File: rtl/gpio_input_path.sv
// Input path: per-pin sleep clamp followed by a two-flop synchronizer.
// Assumes pad_in is asynchronous. The clamp is bypassed for enabled pins.
module gpio_input_path #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         deep,
    input  logic [N-1:0] ien,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] pin_sync
);
    logic [N-1:0] gated;
    logic [N-1:0] s1_q;
    logic [N-1:0] s2_q;

    // Per-pin clamp: force to 0 in deep sleep unless the pin is enabled.
    for (genvar i = 0; i < N; i++) begin : g_clamp
        assign gated[i] = pad_in[i] & ~(deep & ~ien[i]);

        a_r5_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
            (deep && !ien[i]) |=> !s1_q[i]);
    end

    // Two synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= gated;
            s2_q <= s1_q;
        end
    end

    assign pin_sync = s2_q;

endmodule

// File: rtl/gpio_change_det.sv
// Any-change detector: sets a sticky per-pin flag on a difference between
// successive synchronized samples. A clear mask removes flags, and a new
// change takes priority over a clear in the same cycle.
module gpio_change_det #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] prev_q;
    logic [N-1:0] flags_q;

    // Remember the previous sample and update the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            flags_q <= '0;
        end else begin
            prev_q  <= cur;
            flags_q <= (flags_q & ~clr) | (cur ^ prev_q);
        end
    end

    assign flags = flags_q;

    // R7: every change shows up in the flags.
    a_r7_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(cur ^ prev_q)) == $past(cur ^ prev_q)));

    // R7: flags stay set unless cleared.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q & ~clr)) == $past(flags_q & ~clr)));

    // R8: a cleared flag with no new change reads 0.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(clr & ~(cur ^ prev_q))) == '0));

endmodule

// File: rtl/gpio_regs.sv
// Register file and read mux for the port: data, direction, enable.
// Assumes a single-cycle write strobe. Reads are combinational.
module gpio_regs #(
    parameter int N  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    input  logic [N-1:0]  pin_val,
    input  logic [N-1:0]  flag_val,
    output logic [N-1:0]  data_q,
    output logic [N-1:0]  dir_q,
    output logic [N-1:0]  ien_q,
    output logic [N-1:0]  flag_clr,
    output logic [N-1:0]  rdata
);
    import gpio_port_pkg::*;

    logic wr_data, wr_dir, wr_pin, wr_ien, wr_flags;

    assign wr_data  = wr_en && (addr == AW'(OFF_DATA));
    assign wr_dir   = wr_en && (addr == AW'(OFF_DIR));
    assign wr_pin   = wr_en && (addr == AW'(OFF_PIN));
    assign wr_ien   = wr_en && (addr == AW'(OFF_IEN));
    assign wr_flags = wr_en && (addr == AW'(OFF_FLAGS));

    assign flag_clr = wr_flags ? wdata : '0;

    // Writable registers; a pin-offset write toggles the data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            ien_q  <= '0;
        end else begin
            if (wr_data)     data_q <= wdata;
            else if (wr_pin) data_q <= data_q ^ wdata;
            if (wr_dir)      dir_q  <= wdata;
            if (wr_ien)      ien_q  <= wdata;
        end
    end

    // Read mux by offset.
    always_comb begin
        case (addr)
            AW'(OFF_DATA):  rdata = data_q;
            AW'(OFF_DIR):   rdata = dir_q;
            AW'(OFF_PIN):   rdata = pin_val;
            AW'(OFF_IEN):   rdata = ien_q;
            AW'(OFF_FLAGS): rdata = flag_val;
            default:        rdata = '0;
        endcase
    end

    // R9: a toggle write inverts exactly the selected data bits.
    a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pin |=> (data_q == ($past(data_q) ^ $past(wdata))));

endmodule

// File: rtl/gpio_sleep_port.sv
// Top of the sleep-clamped GPIO port: wires the register file, the
// input path and the change detector, and forms the pad controls.
// Assumes the pads resolve pad_out, pad_oe and pad_pu externally.
module gpio_sleep_port #(
    parameter int N  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    output logic [N-1:0]  rdata,
    input  logic [2:0]    sleep_mode,
    input  logic [N-1:0]  pad_in,
    output logic [N-1:0]  pad_out,
    output logic [N-1:0]  pad_oe,
    output logic [N-1:0]  pad_pu,
    output logic          irq
);
    import gpio_port_pkg::*;

    logic [N-1:0] data_q, dir_q, ien_q, flag_clr, pin_sync, flags;
    logic         deep;

    assign deep = is_deep(sleep_mode);

    gpio_regs #(.N(N), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pin_val(pin_sync), .flag_val(flags), .data_q(data_q), .dir_q(dir_q),
        .ien_q(ien_q), .flag_clr(flag_clr), .rdata(rdata)
    );

    gpio_input_path #(.N(N)) u_in (
        .clk(clk), .rst_n(rst_n), .deep(deep), .ien(ien_q),
        .pad_in(pad_in), .pin_sync(pin_sync)
    );

    gpio_change_det #(.N(N)) u_det (
        .clk(clk), .rst_n(rst_n), .cur(pin_sync), .clr(flag_clr), .flags(flags)
    );

    // Pad controls and interrupt.
    assign pad_oe  = dir_q;
    assign pad_out = data_q & dir_q;
    assign pad_pu  = data_q & ~dir_q;
    assign irq     = |(flags & ien_q);

    // R3: pull-up and drive never together on one pin.
    a_r3_pu_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

endmodule

// File: tb/gpio_sleep_port_tb_top.sv
module gpio_sleep_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] sleep_mode = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pu;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_sleep_port dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sleep_mode(sleep_mode), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq)
    );

    // Table entries: {pad_in, sleep_mode, ien, expected pin value}.
    localparam logic [26:0] VEC [8] = '{
        {8'hA5, 3'd0, 8'h00, 8'hA5},
        {8'hA5, 3'd1, 8'h00, 8'hA5},
        {8'hA5, 3'd2, 8'h00, 8'h00},
        {8'hFF, 3'd3, 8'h0F, 8'h0F},
        {8'h3C, 3'd6, 8'hF0, 8'h30},
        {8'hFF, 3'd7, 8'h81, 8'h81},
        {8'hFF, 3'd4, 8'h00, 8'hFF},
        {8'h5A, 3'd5, 8'h00, 8'h5A}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(1);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            bus_read(3'(a), v);
            check("R1 reg reset", v, 8'h00);
        end
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_pu", pad_pu, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        // R5 / R6 table walk
        for (int k = 0; k < 8; k++) begin
            bus_write(3'd3, VEC[k][15:8]);
            @(negedge clk);
            sleep_mode = VEC[k][18:16];
            pad_in = VEC[k][26:19];
            wait_clks(4);
            bus_read(3'd2, v);
            check($sformatf("R5/R6 vector %0d", k), v, VEC[k][7:0]);
        end

        // R4 synchronizer latency
        bus_write(3'd3, 8'h00);
        @(negedge clk);
        sleep_mode = 3'd0; pad_in = 8'h00;
        wait_clks(4);
        bus_write(3'd4, 8'hFF);
        addr = 3'd2;
        @(negedge clk);
        pad_in = 8'h81;
        @(negedge clk);
        #1 check("R4 one edge", rdata, 8'h00);
        @(negedge clk);
        #1 check("R4 two edges", rdata, 8'h81);
        addr = 3'd4;
        #1 check("R7 not before pin", rdata, 8'h00);
        @(negedge clk);
        #1 check("R7 set one edge later", rdata, 8'h81);
        wait_clks(2);
        #1 check("R7 sticky", rdata, 8'h81);

        // R8 partial clear
        bus_write(3'd4, 8'h01);
        bus_read(3'd4, v);
        check("R8 partial clear", v, 8'h80);
        bus_write(3'd4, 8'h80);
        bus_read(3'd4, v);
        check("R8 full clear", v, 8'h00);

        // R7 wake from deep sleep with high pin
        @(negedge clk);
        pad_in = 8'h10;
        wait_clks(4);
        @(negedge clk);
        sleep_mode = 3'd2;
        wait_clks(4);
        bus_write(3'd4, 8'hFF);
        bus_read(3'd2, v);
        check("R5 clamped during sleep", v, 8'h00);
        bus_read(3'd4, v);
        check("R7 flags clear in sleep", v, 8'h00);
        @(negedge clk);
        sleep_mode = 3'd0;
        wait_clks(4);
        bus_read(3'd4, v);
        check("R7 wake sets flag", v, 8'h10);
        check("R10 irq off when disabled", {7'd0, irq}, 8'h00);
        bus_write(3'd3, 8'h10);
        #1 check("R10 irq on", {7'd0, irq}, 8'h01);
        bus_write(3'd4, 8'h10);
        #1 check("R10 irq off after clear", {7'd0, irq}, 8'h00);
        bus_write(3'd3, 8'h00);

        // R2 / R3 pad controls
        bus_write(3'd0, 8'hC3);
        bus_write(3'd1, 8'h0F);
        #1;
        check("R2 pad_oe", pad_oe, 8'h0F);
        check("R2 pad_out", pad_out, 8'h03);
        check("R3 pad_pu", pad_pu, 8'hC0);

        // R9 toggle
        bus_write(3'd2, 8'hFF);
        bus_read(3'd0, v);
        check("R9 toggle all", v, 8'h3C);
        bus_write(3'd2, 8'h05);
        bus_read(3'd0, v);
        check("R9 toggle some", v, 8'h39);
        #1 check("R9 pad_out", pad_out, 8'h09);
        check("R3 pad_pu after toggle", pad_pu, 8'h30);

        // R11 map
        bus_read(3'd1, v);
        check("R11 dir read", v, 8'h0F);
        for (int a = 5; a < 8; a++) begin
            bus_read(3'(a), v);
            check("R11 unmapped", v, 8'h00);
        end

        // R1 reset again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(3'd0, v);
        check("R1 data after reset", v, 8'h00);
        check("R1 pad_oe after reset", pad_oe, 8'h00);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule